// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Processor Core

This block is a 32-bit processor core that completes every instruction in one clock cycle. It holds the program counter and a register file of 32 words. It decodes a small load/store instruction set with three formats, runs operands through an ALU and selects the next fetch address. Instruction and data memory sit outside the core on two separate ports, and both are read combinationally. In a single cycle the core fetches one word, decodes it, reads two registers, computes, optionally loads or stores one data word, and commits its results at the rising clock edge.

All state changes on the rising edge. The program counter is loaded on every edge. The register file and the data-memory write happen only when their write enables are high at that edge. The two register read ports are always addressed by the rs and rt fields, whether or not the instruction uses them. Signed overflow from the trapping add and subtract forms is reported on a status pin and does not change control flow. Instruction fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0], jump target [25:0].

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC is set to 0, and `dmem_we` stays low while `rst_n` is low.
- R2: After any instruction other than a taken branch or a jump, the next fetch address is the current one plus 4.
- R3: R-format (opcode 0x00) results go to register rd. The funct codes are: 0x20 add, 0x21 addu, 0x22 sub, 0x23 subu, 0x24 and, 0x25 or, 0x26 xor, 0x27 nor.
- R4: Immediate forms write register rt. The opcodes are: 0x08 addi and 0x09 addiu, both sign-extending; 0x0C andi, 0x0D ori and 0x0E xori, all zero-extending.
- R5: slt (funct 0x2A) and slti (0x0A, sign-extended immediate) compare as signed. sltu (funct 0x2B) and sltiu (0x0B, sign-extended immediate) compare as unsigned. The result is 1 or 0 in bit 0, and bits 31:1 are zero.
- R6: `ovf_flag` is high only while add, sub or addi overflows in two's complement. addu, subu and addiu never raise it, and no overflow alters the PC.
- R7: lw (0x23) and sw (0x2B) address memory at rs plus the sign-extended immediate. lw writes the loaded word to rt. sw drives `dmem_we` with rt as the data and writes no register.
- R8: beq (0x04) with equal rs and rt loads PC+4 plus the sign-extended immediate shifted left by 2. Otherwise it falls through to PC+4. Backward offsets are included.
- R9: j (0x02) loads the upper four bits of PC+4, followed by the 26-bit target field and then two zero bits.
- R10: Register 0 always reads as zero. A write to it is discarded.
- R11: An unknown opcode, or an unknown funct under opcode 0x00, writes no register and no memory, and execution continues at PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 32 | Fetch address (the current PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data memory write enable, sampled at the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |
| ovf_flag | output | 1 | Signed overflow of add, sub or addi in the current cycle |

## Verification
Assertions check the following on every cycle: sequential PC stepping, the loaded branch and jump targets, that a store never writes a register, that the unsigned add and subtract forms never raise overflow, the signed-compare rule when the operand signs differ, and that a register written in one cycle reads back in the next (register 0 as zero). The actual values that each operation writes can only be shown by the bench's programs. The bench sweeps every ALU operation over boundary operand pairs and stores the results to memory. It also covers the branch paths taken and not taken, the jump, negative load/store offsets, and unknown encodings, all visible through data memory and the fetch trace.

// File: rtl/sc_pkg.sv
// Shared encodings and control types for the single-cycle core.
// Assumes the fixed 32-bit three-format instruction layout.
package sc_pkg;
    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_ADDIU = 6'h09;
    localparam logic [5:0] OP_SLTI  = 6'h0A;
    localparam logic [5:0] OP_SLTIU = 6'h0B;
    localparam logic [5:0] OP_ANDI  = 6'h0C;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_XORI  = 6'h0E;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;

    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_SUBU = 6'h23;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_NOR  = 6'h27;
    localparam logic [5:0] FN_SLT  = 6'h2A;
    localparam logic [5:0] FN_SLTU = 6'h2B;

    typedef enum logic [2:0] {
        ALU_ADD  = 3'd0,
        ALU_SUB  = 3'd1,
        ALU_AND  = 3'd2,
        ALU_OR   = 3'd3,
        ALU_XOR  = 3'd4,
        ALU_NOR  = 3'd5,
        ALU_SLT  = 3'd6,
        ALU_SLTU = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;      // instruction writes a register
        logic    dst_rd;      // destination is rd (else rt)
        logic    alu_imm;     // ALU b operand is the extended immediate
        logic    zero_ext;    // zero-extend immediate (else sign-extend)
        logic    mem_to_reg;  // write-back takes load data
        logic    mem_we;      // store
        logic    branch;      // conditional branch on equality
        logic    jump;        // absolute jump
        logic    use_funct;   // ALU operation comes from funct field
        logic    ovf_en;      // overflow reported for this form
        alu_op_e alu_op;      // ALU operation for non-funct forms
    } ctrl_t;
endpackage

// File: rtl/sc_decoder.sv
// Main decoder: maps the opcode to datapath control.
// Assumes unknown opcodes must produce no side effects (all enables low).
module sc_decoder
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctl
);
    // Opcode to control-word lookup.
    always_comb begin
        ctl = '0;
        unique case (opcode)
            OP_RTYPE: begin
                ctl.reg_we    = 1'b1;
                ctl.dst_rd    = 1'b1;
                ctl.use_funct = 1'b1;
            end
            OP_ADDI: begin
                ctl.reg_we  = 1'b1;
                ctl.alu_imm = 1'b1;
                ctl.ovf_en  = 1'b1;
                ctl.alu_op  = ALU_ADD;
            end
            OP_ADDIU: begin
                ctl.reg_we  = 1'b1;
                ctl.alu_imm = 1'b1;
                ctl.alu_op  = ALU_ADD;
            end
            OP_SLTI: begin
                ctl.reg_we  = 1'b1;
                ctl.alu_imm = 1'b1;
                ctl.alu_op  = ALU_SLT;
            end
            OP_SLTIU: begin
                ctl.reg_we  = 1'b1;
                ctl.alu_imm = 1'b1;
                ctl.alu_op  = ALU_SLTU;
            end
            OP_ANDI: begin
                ctl.reg_we   = 1'b1;
                ctl.alu_imm  = 1'b1;
                ctl.zero_ext = 1'b1;
                ctl.alu_op   = ALU_AND;
            end
            OP_ORI: begin
                ctl.reg_we   = 1'b1;
                ctl.alu_imm  = 1'b1;
                ctl.zero_ext = 1'b1;
                ctl.alu_op   = ALU_OR;
            end
            OP_XORI: begin
                ctl.reg_we   = 1'b1;
                ctl.alu_imm  = 1'b1;
                ctl.zero_ext = 1'b1;
                ctl.alu_op   = ALU_XOR;
            end
            OP_LW: begin
                ctl.reg_we     = 1'b1;
                ctl.alu_imm    = 1'b1;
                ctl.mem_to_reg = 1'b1;
                ctl.alu_op     = ALU_ADD;
            end
            OP_SW: begin
                ctl.alu_imm = 1'b1;
                ctl.mem_we  = 1'b1;
                ctl.alu_op  = ALU_ADD;
            end
            OP_BEQ: begin
                ctl.branch = 1'b1;
                ctl.alu_op = ALU_SUB;
            end
            OP_J: begin
                ctl.jump = 1'b1;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/sc_alu_ctl.sv
// ALU-control decoder: for R-format words it picks the operation from the
// funct field and flags unknown codes; otherwise it passes the main
// decoder's choice through. Assumes the caller gates writes with funct_ok.
module sc_alu_ctl
    import sc_pkg::*;
(
    input  logic       use_funct,
    input  alu_op_e    main_op,
    input  logic       main_ovf_en,
    input  logic [5:0] funct,
    output alu_op_e    alu_op,
    output logic       ovf_en,
    output logic       funct_ok
);
    // Funct-field decode with pass-through for non-R forms.
    always_comb begin
        alu_op   = main_op;
        ovf_en   = main_ovf_en;
        funct_ok = 1'b1;
        if (use_funct) begin
            ovf_en = 1'b0;
            unique case (funct)
                FN_ADD:  begin alu_op = ALU_ADD; ovf_en = 1'b1; end
                FN_ADDU: alu_op = ALU_ADD;
                FN_SUB:  begin alu_op = ALU_SUB; ovf_en = 1'b1; end
                FN_SUBU: alu_op = ALU_SUB;
                FN_AND:  alu_op = ALU_AND;
                FN_OR:   alu_op = ALU_OR;
                FN_XOR:  alu_op = ALU_XOR;
                FN_NOR:  alu_op = ALU_NOR;
                FN_SLT:  alu_op = ALU_SLT;
                FN_SLTU: alu_op = ALU_SLTU;
                default: begin alu_op = ALU_ADD; funct_ok = 1'b0; end
            endcase
        end
    end
endmodule

// File: rtl/sc_alu.sv
// Combinational ALU with zero and two's-complement overflow outputs.
// Assumes overflow is meaningful only for ADD/SUB; the caller gates it.
module sc_alu
    import sc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] res,
    output logic             zero,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic             sub_mode;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum;
    logic             lt_s;
    logic             lt_u;

    // Shared adder: subtraction adds the inverted operand plus one.
    always_comb begin
        sub_mode = (op == ALU_SUB);
        b_eff    = sub_mode ? ~b : b;
        sum      = a + b_eff + {{(WIDTH-1){1'b0}}, sub_mode};
        ovf      = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
        lt_s     = ($signed(a) < $signed(b));
        lt_u     = (a < b);
    end

    // Result select by operation.
    always_comb begin
        unique case (op)
            ALU_ADD, ALU_SUB: res = sum;
            ALU_AND:  res = a & b;
            ALU_OR:   res = a | b;
            ALU_XOR:  res = a ^ b;
            ALU_NOR:  res = ~(a | b);
            ALU_SLT:  res = {{(WIDTH-1){1'b0}}, lt_s};
            ALU_SLTU: res = {{(WIDTH-1){1'b0}}, lt_u};
            default:  res = sum;
        endcase
        zero = (res == '0);
    end

    // With differing signs, the negative operand is the smaller one (R5).
    always_comb begin
        if (op == ALU_SLT && a[MSB] != b[MSB]) begin
            p_slt_sign_rule_r5: assert (res[0] == a[MSB]);
        end
    end
endmodule

// File: rtl/sc_regfile.sv
// Register file: two combinational read ports, one write port committed at
// the rising edge when we is high. Entry 0 holds no storage and reads zero.
// Assumes the caller gates we during reset; contents are not reset.
module sc_regfile #(
    parameter int WIDTH = 32,
    parameter int COUNT = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(COUNT)-1:0] raddr1,
    input  logic [$clog2(COUNT)-1:0] raddr2,
    output logic [WIDTH-1:0]         rdata1,
    output logic [WIDTH-1:0]         rdata2,
    input  logic                     we,
    input  logic [$clog2(COUNT)-1:0] waddr,
    input  logic [WIDTH-1:0]         wdata
);
    localparam int AW = $clog2(COUNT);

    logic [WIDTH-1:0] regs [COUNT];

    // Write port: only nonzero entries take data.
    always_ff @(posedge clk) begin
        if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    // Read ports: entry 0 forced to zero.
    always_comb begin
        rdata1 = (raddr1 == '0) ? '0 : regs[raddr1];
        rdata2 = (raddr2 == '0) ? '0 : regs[raddr2];
    end

    // A committed write is visible on the following cycle (R3).
    p_rf_write_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != AW'(0)) |=> (raddr1 != $past(waddr)) || (rdata1 == $past(wdata)));

    // Writes to entry 0 leave it reading zero (R10).
    p_r0_stays_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == AW'(0)) |=> (raddr1 != AW'(0)) || (rdata1 == '0));
endmodule

// File: rtl/sc_core.sv
// Single-cycle core top: PC register, immediate extension, operand muxing,
// write-back select and next-PC selection around the decoders, the register
// file and the ALU. Assumes combinational instruction and data memories.
module sc_core
    import sc_pkg::*;
#(
    parameter logic [31:0] RESET_PC  = 32'h0000_0000,
    parameter int          REG_COUNT = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata,
    output logic        ovf_flag
);
    localparam int XLEN = 32;
    localparam int RAW  = $clog2(REG_COUNT);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] j_target;
    logic [XLEN-1:0] pc_next;

    logic [5:0]      f_op;
    logic [RAW-1:0]  f_rs;
    logic [RAW-1:0]  f_rt;
    logic [RAW-1:0]  f_rd;
    logic [5:0]      f_funct;
    logic [15:0]     f_imm;
    logic [25:0]     f_target;

    ctrl_t           ctl;
    alu_op_e         alu_op;
    logic            ovf_en;
    logic            funct_ok;

    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_res;
    logic            alu_zero;
    logic            alu_ovf;

    logic            rf_we;
    logic [RAW-1:0]  rf_waddr;
    logic [XLEN-1:0] rf_wdata;
    logic            take_branch;

    // Field split of the fetched word.
    always_comb begin
        f_op     = imem_rdata[31:26];
        f_rs     = imem_rdata[25:21];
        f_rt     = imem_rdata[20:16];
        f_rd     = imem_rdata[15:11];
        f_funct  = imem_rdata[5:0];
        f_imm    = imem_rdata[15:0];
        f_target = imem_rdata[25:0];
    end

    sc_decoder u_dec (
        .opcode (f_op),
        .ctl    (ctl)
    );

    sc_alu_ctl u_alu_ctl (
        .use_funct   (ctl.use_funct),
        .main_op     (ctl.alu_op),
        .main_ovf_en (ctl.ovf_en),
        .funct       (f_funct),
        .alu_op      (alu_op),
        .ovf_en      (ovf_en),
        .funct_ok    (funct_ok)
    );

    sc_regfile #(
        .WIDTH (XLEN),
        .COUNT (REG_COUNT)
    ) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .raddr1 (f_rs),
        .raddr2 (f_rt),
        .rdata1 (rs_val),
        .rdata2 (rt_val),
        .we     (rf_we),
        .waddr  (rf_waddr),
        .wdata  (rf_wdata)
    );

    // Immediate extension and ALU operand select.
    always_comb begin
        imm_ext = ctl.zero_ext ? {16'h0000, f_imm} : {{16{f_imm[15]}}, f_imm};
        alu_b   = ctl.alu_imm ? imm_ext : rt_val;
    end

    sc_alu #(
        .WIDTH (XLEN)
    ) u_alu (
        .op   (alu_op),
        .a    (rs_val),
        .b    (alu_b),
        .res  (alu_res),
        .zero (alu_zero),
        .ovf  (alu_ovf)
    );

    // Write-back destination, data and enable.
    always_comb begin
        rf_waddr = ctl.dst_rd ? f_rd : f_rt;
        rf_wdata = ctl.mem_to_reg ? dmem_rdata : alu_res;
        rf_we    = ctl.reg_we && funct_ok && rst_n;
    end

    // Data memory port and overflow status.
    always_comb begin
        dmem_addr  = alu_res;
        dmem_wdata = rt_val;
        dmem_we    = ctl.mem_we && rst_n;
        ovf_flag   = ovf_en && alu_ovf;
    end

    // Next-PC candidates and selection.
    always_comb begin
        pc_plus4    = pc_q + 32'd4;
        br_target   = pc_plus4 + {imm_ext[29:0], 2'b00};
        j_target    = {pc_plus4[31:28], f_target, 2'b00};
        take_branch = ctl.branch && alu_zero;
        if (ctl.jump) begin
            pc_next = j_target;
        end else if (take_branch) begin
            pc_next = br_target;
        end else begin
            pc_next = pc_plus4;
        end
    end

    // Program counter: loaded every edge, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign imem_addr = pc_q;

    // Sequential step when no control transfer is decoded (R2).
    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.branch && !ctl.jump) |=> (pc_q == $past(pc_q) + 32'd4));

    // Untaken beq falls through (R8).
    p_beq_fallthrough_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.branch && (rs_val != rt_val)) |=> (pc_q == $past(pc_q) + 32'd4));

    // Taken beq loads the relative target (R8).
    p_beq_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.branch && (rs_val == rt_val)) |=> (pc_q == $past(br_target)));

    // Jump keeps the upper PC+4 nibble (R9).
    p_jump_region_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.jump |=> (pc_q[31:28] == $past(pc_plus4[31:28])) && (pc_q[1:0] == 2'b00));

    // A store never writes a register (R7).
    p_store_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> !rf_we);

    // Non-trapping add/sub forms never flag overflow (R6).
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((f_op == OP_ADDIU) ||
         ((f_op == OP_RTYPE) && ((f_funct == FN_ADDU) || (f_funct == FN_SUBU))))
        |-> !ovf_flag);

    // No data write while reset is held (R1).
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> !dmem_we);
endmodule

// File: tb/test_sc_core.sv
// Self-checking bench: small behavioural memories, short programs, results
// inspected through data memory and the fetch-address trace.
module test_sc_core;
    localparam logic [5:0] T_RTYPE = 6'h00, T_J = 6'h02, T_BEQ = 6'h04;
    localparam logic [5:0] T_ADDI = 6'h08, T_LW = 6'h23, T_SW = 6'h2B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, ovf_flag;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    logic        ovf_at [64];
    logic        we_at [64];
    logic        visited [64];
    logic [31:0] trace [64];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign imem_rdata = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    sc_core i_sc_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata),
        .ovf_flag   (ovf_flag)
    );

    function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt);
        return {T_RTYPE, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rt, logic [4:0] rs, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(logic [25:0] tgt);
        return {T_J, tgt};
    endfunction

    function automatic logic [31:0] ref_r(int k, logic [31:0] a, logic [31:0] b);
        case (k)
            0, 1: return a + b;
            2, 3: return a - b;
            4: return a & b;
            5: return a | b;
            6: return a ^ b;
            7: return ~(a | b);
            8: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return (a < b) ? 32'd1 : 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] ref_i(int k, logic [31:0] a, logic [15:0] imm);
        logic [31:0] se = {{16{imm[15]}}, imm};
        logic [31:0] ze = {16'h0, imm};
        case (k)
            0, 1: return a + se;
            2: return ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
            3: return (a < se) ? 32'd1 : 32'd0;
            4: return a & ze;
            5: return a | ze;
            default: return a ^ ze;
        endcase
    endfunction

    function automatic logic add_ovf(logic [31:0] a, logic [31:0] b);
        logic [31:0] s = a + b;
        return (a[31] == b[31]) && (s[31] != a[31]);
    endfunction

    function automatic logic sub_ovf(logic [31:0] a, logic [31:0] b);
        logic [31:0] d = a - b;
        return (a[31] != b[31]) && (d[31] != a[31]);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0000_0000;
            dmem[i] = 32'h0000_0000;
        end
    endtask

    // Reset, check the reset state, then run and record per-cycle observations.
    task automatic run_prog(input int cycles);
        logic [5:0] idx;
        for (int i = 0; i < 64; i++) begin
            ovf_at[i] = 1'b0; we_at[i] = 1'b0; visited[i] = 1'b0; trace[i] = '1;
        end
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 reset pc", imem_addr, 32'h0);
        chk("R1 reset no store", {31'b0, dmem_we}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            #1;
            idx = imem_addr[7:2];
            if (c < 64) trace[c] = imem_addr;
            visited[idx] = 1'b1;
            ovf_at[idx]  = ovf_flag;
            we_at[idx]   = dmem_we;
            if (dmem_we) dmem[dmem_addr[7:2]] = dmem_wdata;
            @(negedge clk);
        end
    endtask

    localparam logic [31:0] OPA [8] = '{32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0005, 32'h1234_5678,
                                        32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0000, 32'h7FFF_FFF0};
    localparam logic [31:0] OPB [8] = '{32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFB, 32'h0F0F_0F0F,
                                        32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0000, 32'h0000_0010};
    localparam logic [15:0] IMMS [8] = '{16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF,
                                         16'h1234, 16'hFFFF, 16'h8000, 16'h0010};
    localparam logic [5:0] FNS [10] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2A, 6'h2B};
    localparam logic [5:0] OPI [7]  = '{6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E};

    // ALU sweep: every R and I operation over boundary operand pairs.
    task automatic sweep();
        for (int p = 0; p < 8; p++) begin
            clear_mem();
            dmem[0]  = OPA[p];
            dmem[1]  = OPB[p];
            dmem[20] = 32'hFFFF_FFFF;
            imem[0] = enc_i(T_LW, 5'd1, 5'd0, 16'd0);
            imem[1] = enc_i(T_LW, 5'd2, 5'd0, 16'd4);
            for (int k = 0; k < 10; k++) imem[2 + k] = enc_r(FNS[k], 5'(3 + k), 5'd1, 5'd2);
            for (int k = 0; k < 7; k++) imem[12 + k] = enc_i(OPI[k], 5'(13 + k), 5'd1, IMMS[p]);
            for (int k = 0; k < 17; k++) imem[19 + k] = enc_i(T_SW, 5'(3 + k), 5'd0, 16'(8 + 4 * k));
            imem[36] = enc_i(T_ADDI, 5'd0, 5'd1, 16'h0005);
            imem[37] = enc_i(T_SW, 5'd0, 5'd0, 16'd80);
            imem[38] = enc_j(26'd38);
            run_prog(45);
            for (int k = 0; k < 10; k++)
                chk((k >= 8) ? "R5 reg compare" : "R3 reg op", dmem[2 + k], ref_r(k, OPA[p], OPB[p]));
            for (int k = 0; k < 7; k++)
                chk((k == 2 || k == 3) ? "R5 imm compare" : "R4 imm op", dmem[12 + k], ref_i(k, OPA[p], IMMS[p]));
            chk("R10 r0 write dropped", dmem[20], 32'h0);
            chk("R6 add ovf", {31'b0, ovf_at[2]}, {31'b0, add_ovf(OPA[p], OPB[p])});
            chk("R6 addu no ovf", {31'b0, ovf_at[3]}, 32'h0);
            chk("R6 sub ovf", {31'b0, ovf_at[4]}, {31'b0, sub_ovf(OPA[p], OPB[p])});
            chk("R6 subu no ovf", {31'b0, ovf_at[5]}, 32'h0);
            chk("R6 addi ovf", {31'b0, ovf_at[12]}, {31'b0, add_ovf(OPA[p], {{16{IMMS[p][15]}}, IMMS[p]})});
            chk("R6 addiu no ovf", {31'b0, ovf_at[13]}, 32'h0);
            chk("R6 no trap path", trace[13], 32'd52);
            if (p == 0) begin
                for (int c = 0; c < 37; c++) chk("R2 sequential pc", trace[c], 32'(4 * c));
                chk("R7 lw no store", {31'b0, we_at[0]}, 32'h0);
                chk("R7 sw store strobe", {31'b0, we_at[19]}, 32'h1);
            end
        end
    endtask

    // Branch and jump program.
    task automatic control_flow();
        clear_mem();
        imem[0]  = enc_i(T_ADDI, 5'd3, 5'd0, 16'h0055);
        imem[1]  = enc_i(T_ADDI, 5'd6, 5'd0, 16'h0066);
        imem[2]  = enc_i(T_ADDI, 5'd1, 5'd0, 16'd7);
        imem[3]  = enc_i(T_ADDI, 5'd2, 5'd0, 16'd7);
        imem[4]  = enc_i(T_BEQ, 5'd2, 5'd1, 16'd2);
        imem[5]  = enc_i(T_ADDI, 5'd3, 5'd0, 16'd1);
        imem[6]  = enc_i(T_ADDI, 5'd3, 5'd0, 16'd2);
        imem[7]  = enc_i(T_ADDI, 5'd4, 5'd0, 16'd9);
        imem[8]  = enc_i(T_BEQ, 5'd0, 5'd1, 16'd5);
        imem[9]  = enc_i(T_ADDI, 5'd5, 5'd0, 16'd3);
        imem[10] = enc_j(26'd14);
        imem[11] = enc_i(T_ADDI, 5'd6, 5'd0, 16'd1);
        imem[12] = enc_i(T_ADDI, 5'd6, 5'd0, 16'd2);
        imem[13] = enc_i(T_ADDI, 5'd6, 5'd0, 16'd3);
        imem[14] = enc_i(T_SW, 5'd3, 5'd0, 16'd0);
        imem[15] = enc_i(T_SW, 5'd4, 5'd0, 16'd4);
        imem[16] = enc_i(T_SW, 5'd5, 5'd0, 16'd8);
        imem[17] = enc_i(T_SW, 5'd6, 5'd0, 16'd12);
        imem[18] = enc_i(T_BEQ, 5'd0, 5'd0, 16'hFFFF);
        run_prog(30);
        chk("R8 beq taken target", trace[5], 32'd28);
        chk("R8 beq not taken", trace[7], 32'd36);
        chk("R9 jump target", trace[9], 32'd56);
        chk("R8 backward beq self", trace[20], 32'd72);
        chk("R8 skipped word 5", {31'b0, visited[5]}, 32'h0);
        chk("R8 skipped word 6", {31'b0, visited[6]}, 32'h0);
        chk("R9 skipped word 12", {31'b0, visited[12]}, 32'h0);
        chk("R8 taken result", dmem[0], 32'h55);
        chk("R8 target executed", dmem[1], 32'd9);
        chk("R8 fallthrough executed", dmem[2], 32'd3);
        chk("R9 jumped-over result", dmem[3], 32'h66);
    endtask

    // Load/store offsets and unknown encodings.
    task automatic mem_and_unknown();
        clear_mem();
        dmem[10] = 32'hAAAA_AAAA;
        imem[0] = enc_i(T_ADDI, 5'd7, 5'd0, 16'd40);
        imem[1] = enc_i(T_ADDI, 5'd1, 5'd0, 16'h1234);
        imem[2] = enc_i(T_SW, 5'd1, 5'd7, 16'hFFF8);
        imem[3] = enc_i(T_LW, 5'd8, 5'd7, 16'hFFF8);
        imem[4] = enc_i(T_SW, 5'd8, 5'd7, 16'd4);
        imem[5] = enc_i(T_ADDI, 5'd3, 5'd0, 16'h0077);
        imem[6] = enc_r(6'h18, 5'd3, 5'd1, 5'd1);
        imem[7] = enc_i(6'h3F, 5'd3, 5'd1, 16'h0004);
        imem[8] = enc_i(T_SW, 5'd3, 5'd7, 16'd0);
        imem[9] = enc_j(26'd9);
        run_prog(14);
        chk("R7 sw negative offset", dmem[8], 32'h1234);
        chk("R7 lw then sw", dmem[11], 32'h1234);
        chk("R11 unknown encodings leave rd/rt", dmem[10], 32'h77);
        chk("R11 unknown funct no store", {31'b0, we_at[6]}, 32'h0);
        chk("R11 unknown opcode no store", {31'b0, we_at[7]}, 32'h0);
        chk("R11 continues at pc+4", trace[8], 32'd32);
    endtask

    initial begin
        sweep();
        control_flow();
        mem_and_unknown();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule